// File: doc/BRIEF.md
# Serial Boot Image Loader

This block sits between a byte-level UART receiver and a local program RAM. After reset it listens for a boot image. The host first sends the image size in bytes as decimal ASCII text and ends it with one blank character (0x20). The raw image follows directly after the blank. The loader writes each image byte into RAM in order, starting at byte address 0. When the final byte has been written, it raises a completion flag. That flag is meant to release the processor from reset.

The loader rejects a header that holds anything unexpected. This covers a non-digit character, a zero size and a size larger than the RAM. After a rejected header it returns to waiting for a new one without writing anything. The RAM port can be a plain byte port or a wider word port with one strobe per byte lane. A parameter chooses between the two. The serial link is expected to run at 115200 bit/s. That leaves many clock cycles between received bytes, so the loader accepts at most one byte per clock cycle.

Top module: `image_loader`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `done` and `ram_we` are both 0.
- R2: In the header, bytes 0x30 to 0x39 are decimal digits, with the most significant digit first, and form the length. A 0x20 blank ends the header, and the byte after it is written to byte address 0.
- R3: Each data byte causes exactly one RAM write, presented on the cycle after its strobe is sampled. Consecutive data bytes go to consecutive byte addresses.
- R4: Byte address n maps to word address n / BUS_BYTES and to lane n mod BUS_BYTES, so the image is stored little-endian. `ram_be` is one-hot on that lane. `ram_wdata` holds the byte in bits 8*lane+7 down to 8*lane, and every other bit of `ram_wdata` is 0.
- R5: In the header, any byte other than a digit or 0x20 discards the digits received so far. The length is then built only from digits that arrive after that byte.
- R6: A header with a length of zero is rejected without any write. This includes a lone blank and digits such as "0" or "00". The loader then waits for a new header.
- R7: A header with a length greater than MEM_BYTES is rejected without any write. The loader then waits for a new header.
- R8: After the header has ended, bytes with the values 0x20 and 0x30 to 0x39 are stored as data and are not parsed.
- R9: `done` rises on the cycle after the write strobe for the last byte. It stays high until reset, and no further write happens while it is high.
- R10: A length equal to MEM_BYTES is accepted and fills every byte address. Leading zero digits do not change the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte | input | 8 | Received byte from the UART receiver |
| rx_strobe | input | 1 | One-cycle pulse: `rx_byte` is valid |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | $clog2(MEM_BYTES/BUS_BYTES) | RAM word address |
| ram_be | output | BUS_BYTES | Byte-lane write strobes |
| ram_wdata | output | 8*BUS_BYTES | Write data, with the byte placed in its lane |
| done | output | 1 | Image complete; releases the processor |

## Verification
A corrupted length or a wrongly accepted header shows up at the RAM port, usually at the very next strobe. It appears either as a write that should not happen or as a word address or lane that does not match the running byte index. The scoreboard compares every write strobe against a queue of expected writes. As a result, the first spurious or misplaced write is reported on the cycle it appears. A byte counter that drifts shows up only at the end: `done` then rises one byte early or late, and this is checked on the exact cycle after the final write.

// File: rtl/loader_pkg.sv
package loader_pkg;

   typedef enum logic [1:0] {
      LD_HDR  = 2'd0,
      LD_DATA = 2'd1,
      LD_DONE = 2'd2
   } ld_state_t;

   localparam logic [7:0] CH_BLANK = 8'h20;
   localparam logic [7:0] CH_ZERO  = 8'h30;
   localparam logic [7:0] CH_NINE  = 8'h39;

   function automatic logic is_digit(input logic [7:0] c);
      return (c >= CH_ZERO) && (c <= CH_NINE);
   endfunction

endpackage

// File: rtl/loader_len_acc.sv
module loader_len_acc
   import loader_pkg::*;
#(
   parameter int MEM_BYTES = 65536,
   localparam int LEN_W = $clog2(MEM_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             in_vld,
   input  logic [7:0]       in_byte,
   output logic             hdr_end,
   output logic             hdr_good,
   output logic [LEN_W-1:0] len_val
);

   localparam int PW = LEN_W + 4;
   localparam logic [PW-1:0] LIMIT = PW'(MEM_BYTES);

   logic [LEN_W-1:0] acc;
   logic             too_big;
   logic [PW-1:0]    wide;
   logic [PW-1:0]    prod;

   assign wide = {4'b0000, acc};
   assign prod = (wide << 3) + (wide << 1) + {{LEN_W{1'b0}}, in_byte[3:0]};

   assign hdr_end  = active && in_vld && (in_byte == CH_BLANK);
   assign hdr_good = !too_big && (acc != '0);
   assign len_val  = acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         too_big <= 1'b0;
      end else if (active && in_vld) begin
         if (is_digit(in_byte)) begin
            if (prod > LIMIT) begin
               too_big <= 1'b1;
            end else if (!too_big) begin
               acc <= prod[LEN_W-1:0];
            end
         end else begin
            acc     <= '0;
            too_big <= 1'b0;
         end
      end
   end

   assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      acc <= LEN_W'(MEM_BYTES));

   assert_clear_on_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && in_vld && !is_digit(in_byte)) |=> (acc == '0 && !too_big));

endmodule

// File: rtl/loader_seq.sv
module loader_seq
   import loader_pkg::*;
#(
   parameter int MEM_BYTES = 65536,
   localparam int LEN_W = $clog2(MEM_BYTES + 1),
   localparam int CNT_W = $clog2(MEM_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [7:0]       in_byte,
   input  logic             hdr_end,
   input  logic             hdr_good,
   input  logic [LEN_W-1:0] len_val,
   output logic             in_hdr,
   output logic             wr_q,
   output logic [CNT_W-1:0] idx_q,
   output logic [7:0]       byte_q,
   output logic             done_q
);

   ld_state_t        st;
   logic [CNT_W-1:0] cnt;
   logic [LEN_W-1:0] len_q;
   logic             last_q;
   logic             is_last;

   assign in_hdr  = (st == LD_HDR);
   assign is_last = (LEN_W'({1'b0, cnt}) + LEN_W'(1)) == len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= LD_HDR;
         cnt    <= '0;
         len_q  <= '0;
         wr_q   <= 1'b0;
         idx_q  <= '0;
         byte_q <= '0;
         last_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         wr_q   <= 1'b0;
         last_q <= 1'b0;
         if (wr_q && last_q) done_q <= 1'b1;
         unique case (st)
            LD_HDR: begin
               if (hdr_end && hdr_good) begin
                  st    <= LD_DATA;
                  len_q <= len_val;
                  cnt   <= '0;
               end
            end
            LD_DATA: begin
               if (in_vld) begin
                  wr_q   <= 1'b1;
                  idx_q  <= cnt;
                  byte_q <= in_byte;
                  cnt    <= cnt + CNT_W'(1);
                  if (is_last) begin
                     last_q <= 1'b1;
                     st     <= LD_DONE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assert_write_from_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> $past(in_vld));

   assert_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LD_DATA && in_vld && !is_last) |=> (cnt == $past(cnt) + CNT_W'(1)));

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done_q) |-> done_q);

   assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !wr_q);

endmodule

// File: rtl/loader_wport.sv
module loader_wport #(
   parameter int CNT_W     = 16,
   parameter int BUS_BYTES = 4,
   localparam int LANE_W = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1,
   localparam int ADDR_W = CNT_W - $clog2(BUS_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic [CNT_W-1:0]       idx,
   input  logic [7:0]             data,
   output logic                   we,
   output logic [ADDR_W-1:0]      addr,
   output logic [BUS_BYTES-1:0]   be,
   output logic [8*BUS_BYTES-1:0] wdata
);

   assign we = wr;

   generate
      if (BUS_BYTES == 1) begin : g_byte_port
         assign addr  = idx;
         assign be    = 1'b1;
         assign wdata = data;
      end else begin : g_word_port
         logic [LANE_W-1:0] lane;
         assign lane = idx[LANE_W-1:0];
         assign addr = idx[CNT_W-1:LANE_W];
         for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
            assign be[k]            = (lane == LANE_W'(k));
            assign wdata[8*k +: 8]  = (lane == LANE_W'(k)) ? data : 8'h00;
         end
      end
   endgenerate

   assert_single_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> ($countones(be) == 1));

   assert_lane_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(be));

endmodule

// File: rtl/image_loader.sv
module image_loader #(
   parameter int MEM_BYTES = 65536,
   parameter int BUS_BYTES = 4,
   localparam int CNT_W  = $clog2(MEM_BYTES),
   localparam int LEN_W  = $clog2(MEM_BYTES + 1),
   localparam int ADDR_W = CNT_W - $clog2(BUS_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [7:0]             rx_byte,
   input  logic                   rx_strobe,
   output logic                   ram_we,
   output logic [ADDR_W-1:0]      ram_addr,
   output logic [BUS_BYTES-1:0]   ram_be,
   output logic [8*BUS_BYTES-1:0] ram_wdata,
   output logic                   done
);

   generate
      if ((MEM_BYTES & (MEM_BYTES - 1)) != 0 || MEM_BYTES < 2) begin : g_bad_mem
         $error("image_loader: MEM_BYTES must be a power of two of at least 2");
      end
      if (BUS_BYTES != 1 && BUS_BYTES != 2 && BUS_BYTES != 4 && BUS_BYTES != 8) begin : g_bad_bus
         $error("image_loader: BUS_BYTES must be 1, 2, 4 or 8");
      end
      if (BUS_BYTES >= MEM_BYTES) begin : g_bad_ratio
         $error("image_loader: BUS_BYTES must be smaller than MEM_BYTES");
      end
   endgenerate

   logic             in_hdr;
   logic             hdr_end;
   logic             hdr_good;
   logic [LEN_W-1:0] len_val;
   logic             wr_q;
   logic [CNT_W-1:0] idx_q;
   logic [7:0]       byte_q;

   loader_len_acc #(.MEM_BYTES(MEM_BYTES)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (in_hdr),
      .in_vld   (rx_strobe),
      .in_byte  (rx_byte),
      .hdr_end  (hdr_end),
      .hdr_good (hdr_good),
      .len_val  (len_val)
   );

   loader_seq #(.MEM_BYTES(MEM_BYTES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (rx_strobe),
      .in_byte  (rx_byte),
      .hdr_end  (hdr_end),
      .hdr_good (hdr_good),
      .len_val  (len_val),
      .in_hdr   (in_hdr),
      .wr_q     (wr_q),
      .idx_q    (idx_q),
      .byte_q   (byte_q),
      .done_q   (done)
   );

   loader_wport #(.CNT_W(CNT_W), .BUS_BYTES(BUS_BYTES)) u_wport (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_q),
      .idx   (idx_q),
      .data  (byte_q),
      .we    (ram_we),
      .addr  (ram_addr),
      .be    (ram_be),
      .wdata (ram_wdata)
   );

   assert_first_cycle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!ram_we && !done));

   assert_no_write_in_header_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_hdr) && in_hdr) |-> !ram_we);

endmodule

// File: tb/image_loader_test.sv
module image_loader_test;

   localparam int MEM  = 1024;
   localparam int BUS  = 4;
   localparam int AW   = $clog2(MEM / BUS);

   typedef struct packed {
      logic [AW-1:0]    addr;
      logic [BUS-1:0]   be;
      logic [8*BUS-1:0] data;
   } wr_item_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [7:0]       rx_byte = 8'h00;
   logic             rx_strobe = 1'b0;
   logic             ram_we;
   logic [AW-1:0]    ram_addr;
   logic [BUS-1:0]   ram_be;
   logic [8*BUS-1:0] ram_wdata;
   logic             done;

   int errors = 0;
   int checks = 0;
   wr_item_t expq[$];

   always #4 clk = ~clk;

   image_loader #(.MEM_BYTES(MEM), .BUS_BYTES(BUS)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_byte   (rx_byte),
      .rx_strobe (rx_strobe),
      .ram_we    (ram_we),
      .ram_addr  (ram_addr),
      .ram_be    (ram_be),
      .ram_wdata (ram_wdata),
      .done      (done)
   );

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every write strobe is compared with the queue head
   always @(negedge clk) begin
      if (rst_n && ram_we) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R3/R6/R7/R9 unexpected write", 64'(ram_addr), 64'hFFFF);
         end else begin
            wr_item_t e;
            e = expq.pop_front();
            chk(ram_addr == e.addr, "R3 word address", 64'(ram_addr), 64'(e.addr));
            chk(ram_be == e.be, "R4 lane strobe", 64'(ram_be), 64'(e.be));
            chk(ram_wdata == e.data, "R4/R8 lane data", 64'(ram_wdata), 64'(e.data));
         end
      end
   end

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      rx_byte   = b;
      rx_strobe = 1'b1;
      @(negedge clk);
      rx_strobe = 1'b0;
   endtask

   task automatic send_str(input string s);
      for (int i = 0; i < s.len(); i++) send(s[i]);
   endtask

   task automatic expect_byte(input int n, input logic [7:0] b);
      wr_item_t e;
      e.addr = AW'(n / BUS);
      e.be   = BUS'(1) << (n % BUS);
      e.data = (8*BUS)'(b) << (8 * (n % BUS));
      expq.push_back(e);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R1 done in reset", 64'(done), 0);
      chk(ram_we == 1'b0, "R1 we in reset", 64'(ram_we), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && ram_we == 1'b0, "R1 after release", 64'({done, ram_we}), 0);
   endtask

   // sends n data bytes, expecting them; checks done timing on the last one (R9)
   task automatic load_bytes(input int n, input int mul, input int add);
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         b = 8'((i * mul + add) & 8'hFF);
         expect_byte(i, b);
         send(b);
      end
      chk(done == 1'b0, "R9 done not with last write", 64'(done), 0);
      @(negedge clk);
      chk(done == 1'b1, "R9 done one cycle after last write", 64'(done), 1);
      chk(expq.size() == 0, "R3 all bytes written", 64'(expq.size()), 0);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [7:0] pay [5];
      pay = '{8'h20, 8'h31, 8'hAA, 8'h39, 8'h7F};

      do_reset();

      // R6: zero lengths, R7: oversize lengths, R5: junk in header
      send_str(" ");
      send_str("0 ");
      send_str("00 ");
      send_str(1025 == MEM + 1 ? "1025 " : "1025 ");
      send_str("99999999 ");
      send_str("ab");
      repeat (4) @(negedge clk);
      chk(done == 1'b0, "R6/R7 rejected headers leave done low", 64'(done), 0);
      chk(expq.size() == 0, "R6/R7 no pending", 64'(expq.size()), 0);

      // R5: "12x5" -> length 5; R2 header end; R8 blank/digits as data
      send_str("12x5 ");
      for (int i = 0; i < 5; i++) begin
         expect_byte(i, pay[i]);
         send(pay[i]);
      end
      chk(done == 1'b0, "R9 done not with last write", 64'(done), 0);
      @(negedge clk);
      chk(done == 1'b1, "R9 done after 5 bytes (R2/R5)", 64'(done), 1);
      chk(expq.size() == 0, "R8 all data bytes stored", 64'(expq.size()), 0);

      // R9: further bytes ignored, done sticky
      send_str("3 ab");
      repeat (4) @(negedge clk);
      chk(done == 1'b1, "R9 done stays high", 64'(done), 1);

      // R10: maximum length
      do_reset();
      send_str("1024 ");
      load_bytes(MEM, 13, 5);

      // R10: leading zeros
      do_reset();
      send_str("007 ");
      load_bytes(7, 1, 8'h30);

      // R7 then accept: oversize first, then a good header
      do_reset();
      send_str("2000 ");
      send_str("3 ");
      load_bytes(3, 17, 1);

      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule